// File: doc/BRIEF.md
# Power-Fail Write-Protect SRAM Controller

This block places a supply-aware guard in front of a small synchronous memory array that is modelled inside it. The host side uses the usual SRAM control set: active-low chip select, write strobe and output enable, an address, and a data bus. The data bus is split into an input, an output and an output-enable, as it would be inside a chip. Two digitized comparator inputs report the supply state. One says whether the supply is above the power-fail threshold. The other says whether it is above the level at which the retention cell should take over.

While the supply is good, the block behaves as a plain SRAM. When the supply falls, it locks the host out: the bus is released and every host input is ignored. There is one exception. An access already under way when the fall is seen may continue for a bounded number of cycles. After the supply comes back, the lock holds for a recovery delay before access reopens.

A retention-source selector moves the array onto the backup cell when the supply drops below the switchover level. It moves it back when the supply rises above that level. A one-shot isolation flag models the shipped condition: while it is set, the backup cell is never used, and a deep supply drop erases the array. All times are clock-cycle counts set by parameters.

Top module: `pfsram_guard`

## Requirements
- R1: After reset, `state_o` is 2 (locked), `iso_flag` is 1, `on_backup` is 0 and `dq_oe` is 0. The state codes are: 0 normal, 1 draining, 2 locked, 3 recovering.
- R2: In state 0, with `ce_n`=0, `we_n`=1 and `oe_n`=0, `dq_oe` is 1 in the same cycle and `dq_o` equals the word stored at `addr`.
- R3: `dq_oe` is 0 whenever `ce_n`=1, and whenever `ce_n`=0 with `we_n`=1 and `oe_n`=1.
- R4: In state 0, with `ce_n`=0 and `we_n`=0, the rising edge stores `dq_i` at `addr` whatever `oe_n` is, and `dq_oe` stays 0.
- R5: In state 2, a clock edge that sees `vcc_ok`=1 moves the block to state 3. It then stays in state 3 for T_CER cycles and enters state 0 on the next edge. If `vcc_ok` is 0 at an edge during state 3, the block returns to state 2.
- R6: In states 2 and 3, `dq_oe` is 0 and write strobes do not change the array.
- R7: In state 0, an edge that sees `vcc_ok`=0 while `ce_n`=1 moves the block straight to state 2.
- R8: In state 0, an edge that sees `vcc_ok`=0 while `ce_n`=0 moves the block to state 1. Reads and writes are still accepted there. The first edge that sees `ce_n`=1 moves it to state 2.
- R9: An access kept open after the fall is honoured for T_WPT cycles, counting the cycle in which `vcc_ok` first reads 0. In the following cycle the bus is released and any write is dropped. The next edge enters state 2.
- R10: `iso_flag` clears on the first edge that sees `vcc_ok`=1. Only reset sets it again.
- R11: With `iso_flag`=0, `on_backup` becomes 1 on the edge after `vcc_above_sw` goes to 0, and returns to 0 on the edge after it goes back to 1. The array contents survive.
- R12: With `iso_flag`=1, an edge that sees `vcc_above_sw`=0 clears every word of the array to 0, and `on_backup` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array and control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vcc_ok | input | 1 | Supply above the power-fail threshold |
| vcc_above_sw | input | 1 | Supply above the backup switchover level |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| dq_i | input | DW | Write data from the host |
| dq_o | output | DW | Read data to the host |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| state_o | output | 2 | Protection state code (see R1) |
| on_backup | output | 1 | Array is held by the backup cell |
| iso_flag | output | 1 | Backup cell still isolated |

## Verification
The bound checker watches the protection sequence on every cycle. It checks that the bus is never driven while locked or recovering and that it is driven only in read mode. It checks the edges into the locked and recovering states, that the drain window never runs longer than T_WPT cycles and is quiet in its last cycle, and that the isolation flag and the backup selection stay consistent. Other behaviour needs the bench's scenarios, because it can only be seen through later reads. That covers whether a write made during the drain or the lockout really reached the array, whether data survives a trip onto the backup cell, and whether an isolated deep drop wipes every word.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_LOCKED  = 2'd2,
    ST_RECOVER = 2'd3
  } pf_state_e;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_HIZ   = 2'd1,
    MD_READ  = 2'd2,
    MD_WRITE = 2'd3
  } bus_mode_e;

endpackage

// File: rtl/pfsram_mode_dec.sv
module pfsram_mode_dec
  import pfsram_pkg::*;
(
  input  logic      ce_n,
  input  logic      we_n,
  input  logic      oe_n,
  output bus_mode_e mode
);

  always_comb begin
    if (ce_n)       mode = MD_IDLE;
    else if (!we_n) mode = MD_WRITE;   // output enable is ignored here
    else if (!oe_n) mode = MD_READ;
    else            mode = MD_HIZ;
  end

endmodule

// File: rtl/pfsram_guard_fsm.sv
module pfsram_guard_fsm
  import pfsram_pkg::*;
#(
  parameter int T_WPT = 4,
  parameter int T_CER = 5
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      vcc_ok,
  input  logic      ce_n,
  output pf_state_e state,
  output logic      access_ok
);

  localparam int TMAX = (T_WPT > T_CER) ? T_WPT : T_CER;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] WPT_LAST = CW'(T_WPT - 1);
  localparam logic [CW-1:0] CER_LAST = CW'(T_CER - 1);

  pf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (!vcc_ok) begin
          cnt_d   = '0;
          state_d = ce_n ? ST_LOCKED : ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (ce_n || (cnt_q == WPT_LAST)) state_d = ST_LOCKED;
        else                             cnt_d   = cnt_q + 1'b1;
      end
      ST_LOCKED: begin
        if (vcc_ok) begin
          state_d = ST_RECOVER;
          cnt_d   = '0;
        end
      end
      ST_RECOVER: begin
        if (!vcc_ok)                state_d = ST_LOCKED;
        else if (cnt_q == CER_LAST) state_d = ST_NORMAL;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // The drain window closes one cycle before the forced lock.
  assign access_ok = (state_q == ST_NORMAL) ||
                     ((state_q == ST_DRAIN) && (cnt_q != WPT_LAST));
  assign state     = state_q;

endmodule

// File: rtl/pfsram_supply_sel.sv
module pfsram_supply_sel (
  input  logic clk,
  input  logic rst_ni,
  input  logic vcc_ok,
  input  logic vcc_above_sw,
  output logic iso,
  output logic on_backup,
  output logic wipe
);

  logic iso_d, bk_d;

  always_comb begin
    iso_d = iso & ~vcc_ok;
    bk_d  = ~iso & ~vcc_above_sw;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      iso       <= 1'b1;
      on_backup <= 1'b0;
    end else begin
      iso       <= iso_d;
      on_backup <= bk_d;
    end
  end

  // A deep supply drop with the cell still isolated loses the array.
  assign wipe = iso & ~vcc_above_sw;

endmodule

// File: rtl/pfsram_array.sv
module pfsram_array #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wipe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == AW'(w));
    always_ff @(posedge clk) begin
      if (wipe)     mem[w] <= '0;
      else if (hit) mem[w] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/pfsram_guard.sv
module pfsram_guard
  import pfsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int T_WPT = 8,
  parameter int T_CER = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vcc_ok,
  input  logic          vcc_above_sw,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [1:0]    state_o,
  output logic          on_backup,
  output logic          iso_flag
);

  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  bus_mode_e     mode;
  pf_state_e     state;
  logic          access_ok, wr_en, wipe;
  logic [DW-1:0] rdata;

  pfsram_mode_dec u_dec (
    .ce_n (ce_n),
    .we_n (we_n),
    .oe_n (oe_n),
    .mode (mode)
  );

  pfsram_guard_fsm #(.T_WPT(T_WPT), .T_CER(T_CER)) u_fsm (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .vcc_ok    (vcc_ok),
    .ce_n      (ce_n),
    .state     (state),
    .access_ok (access_ok)
  );

  pfsram_supply_sel u_sup (
    .clk          (clk),
    .rst_ni       (rst_sync_n),
    .vcc_ok       (vcc_ok),
    .vcc_above_sw (vcc_above_sw),
    .iso          (iso_flag),
    .on_backup    (on_backup),
    .wipe         (wipe)
  );

  assign wr_en = access_ok && (mode == MD_WRITE);
  assign dq_oe = access_ok && (mode == MD_READ);

  pfsram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .wr_en (wr_en),
    .wipe  (wipe),
    .addr  (addr),
    .wdata (dq_i),
    .rdata (rdata)
  );

  assign dq_o    = dq_oe ? rdata : '0;
  assign state_o = state;

endmodule

// File: rtl/pfsram_guard_chk.sv
module pfsram_guard_chk
  import pfsram_pkg::*;
#(
  parameter int T_WPT = 8
) (
  input logic      clk,
  input logic      rst_ni,
  input logic      vcc_ok,
  input logic      ce_n,
  input logic      we_n,
  input logic      oe_n,
  input pf_state_e state,
  input logic      dq_oe,
  input logic      wr_en,
  input logic      iso,
  input logic      on_backup
);

  logic [31:0] drain_run;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                drain_run <= '0;
    else if (state == ST_DRAIN) drain_run <= drain_run + 1;
    else                        drain_run <= '0;
  end

  // R6
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_LOCKED || state == ST_RECOVER) |-> (!dq_oe && !wr_en));

  // R3
  drive_read_only_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    dq_oe |-> (!ce_n && we_n && !oe_n));

  // R10
  iso_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !iso |=> !iso);

  // R11
  backup_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    on_backup |-> !iso);

  // R5
  lock_to_recover_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_LOCKED && vcc_ok) |=> (state == ST_RECOVER));

  // R7
  idle_fall_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_NORMAL && !vcc_ok && ce_n) |=> (state == ST_LOCKED));

  // R8
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_DRAIN && ce_n) |=> (state == ST_LOCKED));

  // R9
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_DRAIN) |-> (drain_run < 32'(T_WPT)));

  // R9
  drain_last_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_DRAIN && drain_run == 32'(T_WPT - 1)) |-> (!dq_oe && !wr_en));

endmodule

bind pfsram_guard pfsram_guard_chk #(.T_WPT(T_WPT)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .vcc_ok    (vcc_ok),
  .ce_n      (ce_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .state     (state),
  .dq_oe     (dq_oe),
  .wr_en     (wr_en),
  .iso       (iso_flag),
  .on_backup (on_backup)
);

// File: tb/pfsram_guard_bench.sv
`timescale 1ns/1ps
module pfsram_guard_bench;

  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int T_WPT = 4;
  localparam int T_CER = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, vcc_ok, vcc_above_sw, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe, on_backup, iso_flag;
  logic [1:0]    state_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pfsram_guard #(.AW(AW), .DW(DW), .T_WPT(T_WPT), .T_CER(T_CER)) u_pfsram_guard (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_above_sw(vcc_above_sw),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .state_o(state_o), .on_backup(on_backup),
    .iso_flag(iso_flag)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 7);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic read_chk(input string req, input int a, input logic [DW-1:0] exp);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
    #1;
    chk(req, {31'd0, dq_oe}, 32'd1);
    chk(req, {24'd0, dq_o}, {24'd0, exp});
    idle();
  endtask

  task automatic power_up();
    idle();
    vcc_ok = 1'b1;
    tick(T_CER + 1);
  endtask

  task automatic power_down();
    idle();
    vcc_ok = 1'b0;
    tick(1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vcc_ok = 1'b0; vcc_above_sw = 1'b1;
    idle(); addr = '0; dq_i = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state; R6 a read attempt is ignored while locked
    chk("R1 state", {30'd0, state_o}, 32'd2);
    chk("R1 iso", {31'd0, iso_flag}, 32'd1);
    chk("R1 backup", {31'd0, on_backup}, 32'd0);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R1/R6 bus", {31'd0, dq_oe}, 32'd0);
    idle();

    // R5 R10 power-up sequence
    vcc_ok = 1'b1;
    tick(1);
    chk("R5 enter recover", {30'd0, state_o}, 32'd3);
    chk("R10 iso cleared", {31'd0, iso_flag}, 32'd0);
    tick(T_CER - 1);
    chk("R5 still recover", {30'd0, state_o}, 32'd3);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R6 no drive recover", {31'd0, dq_oe}, 32'd0);
    idle();
    tick(1);
    chk("R5 normal", {30'd0, state_o}, 32'd0);

    // R4 write sweep, oe_n varied; R2 read sweep
    for (int a = 0; a < DEPTH; a++) begin
      ce_n = 1'b0; we_n = 1'b0; oe_n = a[0]; addr = AW'(a); dq_i = pat(a);
      #1;
      chk("R4 no drive on write", {31'd0, dq_oe}, 32'd0);
      tick(1);
    end
    idle();
    for (int a = 0; a < DEPTH; a++) read_chk("R2/R4 readback", a, pat(a));

    // R3 undriven modes
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; #1;
    chk("R3 deselect", {31'd0, dq_oe}, 32'd0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R3 output off", {31'd0, dq_oe}, 32'd0);
    idle();

    // R7 idle fall; R6 writes ignored while locked or recovering
    power_down();
    chk("R7 locked", {30'd0, state_o}, 32'd2);
    ce_n = 1'b0; we_n = 1'b0; addr = 3'd1; dq_i = 8'h55;
    tick(2);
    addr = 3'd2; dq_i = 8'h66; vcc_ok = 1'b1;
    tick(T_CER);
    idle();
    tick(1);
    chk("R5 normal again", {30'd0, state_o}, 32'd0);
    read_chk("R6 lock write dropped", 1, pat(1));
    read_chk("R6 recover write dropped", 2, pat(2));

    // R5 supply lost during recovery
    power_down();
    vcc_ok = 1'b1; tick(1);
    chk("R5 recover", {30'd0, state_o}, 32'd3);
    vcc_ok = 1'b0; tick(1);
    chk("R5 back to lock", {30'd0, state_o}, 32'd2);
    power_up();

    // R8 drain ended by deselect
    ce_n = 1'b0; we_n = 1'b0; addr = 3'd3; dq_i = 8'hA1; vcc_ok = 1'b0;
    tick(1);
    chk("R8 drain", {30'd0, state_o}, 32'd1);
    dq_i = 8'hA2;
    tick(1);
    chk("R8 still drain", {30'd0, state_o}, 32'd1);
    idle();
    tick(1);
    chk("R8 lock after deselect", {30'd0, state_o}, 32'd2);
    power_up();
    read_chk("R8 drain write kept", 3, 8'hA2);

    // R9 timeout drops a pending write
    ce_n = 1'b0; we_n = 1'b0; addr = 3'd4; dq_i = 8'hB1; vcc_ok = 1'b0;
    tick(T_WPT);
    chk("R9 drain at limit", {30'd0, state_o}, 32'd1);
    dq_i = 8'hB2;
    tick(1);
    chk("R9 forced lock", {30'd0, state_o}, 32'd2);
    power_up();
    read_chk("R9 late write dropped", 4, 8'hB1);

    // R9 read released in the last drain cycle
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 3'd6; vcc_ok = 1'b0;
    tick(T_WPT - 1);
    chk("R9 read still open", {31'd0, dq_oe}, 32'd1);
    tick(1);
    chk("R9 read released", {31'd0, dq_oe}, 32'd0);
    idle();
    tick(1);

    // R11 trip onto the backup cell
    vcc_above_sw = 1'b0; tick(1);
    chk("R11 on backup", {31'd0, on_backup}, 32'd1);
    vcc_above_sw = 1'b1; tick(1);
    chk("R11 back on main", {31'd0, on_backup}, 32'd0);
    power_up();
    read_chk("R11 data kept", 5, pat(5));

    // R12 isolated deep drop wipes the array
    vcc_ok = 1'b0; tick(1);
    rst_n = 1'b0; tick(1);
    rst_n = 1'b1; tick(3);
    chk("R10 iso set by reset", {31'd0, iso_flag}, 32'd1);
    vcc_above_sw = 1'b0; tick(1);
    chk("R12 no backup while isolated", {31'd0, on_backup}, 32'd0);
    vcc_above_sw = 1'b1; tick(1);
    chk("R10 iso held while supply low", {31'd0, iso_flag}, 32'd1);
    power_up();
    for (int a = 0; a < DEPTH; a++) read_chk("R12 wiped", a, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule